// File: doc/BRIEF.md
# ADC Scan Sequencer with Trigger Qualification

This block decides when an external successive-approximation converter runs and on which input. It takes a converter enable, a two-bit operating mode, a per-channel enable mask, a software start/stop request pair and an optional hardware trigger pin. From these it runs a start/done handshake with the converter and drives the channel number that goes with each start. It also reports a busy bit and raises a sticky end-of-conversion flag with an interrupt. The converter is seen only through that handshake.

Three modes exist. Single mode converts one channel. Scan-once mode walks every enabled channel in ascending order and stops. Continuous mode repeats that walk until software stops it. A hardware trigger can replace the software start, but only in scan-once mode. The pin first passes through a synchronizer and a filter that counts stable cycles. Level conditions need a long stable run. Edge conditions need a shorter run on both sides of the transition.

Top module: `adc_scan_seq`

## Requirements
- R1: The mode code `cfg_mode` means 00 = single, 01 = reserved, 10 = scan-once, 11 = continuous. A start request while the code is 01 is ignored: busy stays 0 and no conversion starts.
- R2: In single mode a start converts only the lowest-numbered enabled channel, once. Busy then returns to 0 and the end flag is set.
- R3: In scan-once mode every enabled channel is converted exactly once, in ascending order, and disabled channels are skipped. Busy returns to 0 after the last one, and the end flag is set.
- R4: In continuous mode the pass over enabled channels repeats with busy held at 1. The end flag is set at the end of each pass.
- R5: A stop request (`sw_start_clr`) drops busy at the next clock edge, and no further `conv_start` follows.
- R6: While `cfg_enable` is 0 no conversion starts, and dropping it during a run aborts the run at the next edge.
- R7: With an all-zero channel mask a start completes at once, with no conversion, and still sets the end flag.
- R8: The end flag stays set until a 1 is written through `eoc_clr`, and a new end event wins over a clear in the same cycle. `irq` equals the end flag ANDed with `cfg_irq_en`.
- R9: A qualified hardware trigger starts a run only when `cfg_hw_trig_en` is 1, the mode is scan-once (10) and the block is idle. It has no effect in any other mode.
- R10: The trigger condition code `cfg_trig_cond` means 00 = low level, 01 = high level, 10 = falling edge, 11 = rising edge. A level condition is accepted once the synchronized pin has held the active level for LEVEL_HOLD (default 8) consecutive cycles, and it fires once per such run.
- R11: An edge condition is accepted only when the level before the transition lasted at least EDGE_HOLD (default 4) cycles and the new level has also held for EDGE_HOLD cycles. A 3-cycle pulse is rejected.
- R12: `conv_start` is a one-cycle pulse issued only while busy, with `cur_chan` (4 bits) naming the channel. The next channel is selected after `conv_done`. `busy` rises at the edge after a start request is accepted.
- R13: After reset, busy, end flag, interrupt and `conv_start` are 0 and `cur_chan` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Converter enable; 0 blocks and aborts runs |
| cfg_mode | input | 2 | Operating mode code |
| cfg_chan_mask | input | NUM_CH | Channel enable mask, bit i = channel i |
| cfg_irq_en | input | 1 | Interrupt enable for the end flag |
| cfg_hw_trig_en | input | 1 | Hardware trigger enable |
| cfg_trig_cond | input | 2 | Trigger condition code |
| sw_start_set | input | 1 | Software start request pulse |
| sw_start_clr | input | 1 | Software stop request pulse |
| eoc_clr | input | 1 | Write-one-to-clear pulse for the end flag |
| trig_pin | input | 1 | Asynchronous trigger pin |
| conv_done | input | 1 | Converter completion pulse |
| conv_start | output | 1 | Converter start pulse |
| cur_chan | output | CH_W | Channel being converted |
| busy | output | 1 | Run in progress |
| eoc_flag | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |

## Verification
Busy is due one edge after a start or stop pulse, and the bench samples it at the following falling edge. A conversion pass finishes a variable number of cycles later, because the converter model answers each start after a fixed latency. The bench therefore waits for busy to fall, allows two more cycles, and only then compares the logged channel sequence, the end flag and the interrupt. A trigger is accepted only after the synchronizer stages plus the hold count, so each pin pattern is followed by a 20-cycle settle window. The check then compares the number of conversions started against the expected increment of zero or one.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      MODE_ONE  = 2'b00,
      MODE_RSV  = 2'b01,
      MODE_SCAN = 2'b10,
      MODE_LOOP = 2'b11
   } seq_mode_e;

   typedef enum logic [1:0] {
      TRIG_LOW  = 2'b00,
      TRIG_HIGH = 2'b01,
      TRIG_FALL = 2'b10,
      TRIG_RISE = 2'b11
   } trig_cond_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_ISSUE = 2'b01,
      ST_WAIT  = 2'b10
   } seq_state_e;

endpackage

// File: rtl/adc_trig_qual.sv
module adc_trig_qual
   import adc_seq_pkg::*;
#(
   parameter int LEVEL_HOLD  = 8,
   parameter int EDGE_HOLD   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] cond,
   output logic       fire
);

   localparam int RUN_MAX = LEVEL_HOLD + 1;
   localparam int CW      = $clog2(RUN_MAX + 1);

   generate
      if (EDGE_HOLD < 2 || LEVEL_HOLD < EDGE_HOLD) begin : g_bad_hold
         $error("adc_trig_qual: need 2 <= EDGE_HOLD <= LEVEL_HOLD");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("adc_trig_qual: SYNC_STAGES must be non-negative");
      end
   endgenerate

   logic pin_s;

   // Synchronizer depth is a build option; zero stages feeds the pin straight in.
   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign pin_s = pin;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '0;
            else        sr <= (sr << 1) | SYNC_STAGES'(pin);
         end
         assign pin_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   logic          lvl_q;
   logic [CW-1:0] run;
   logic          long_prev;

   // run counts how many cycles lvl_q has held its value, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q     <= 1'b0;
         run       <= '0;
         long_prev <= 1'b0;
      end else if (pin_s != lvl_q) begin
         lvl_q     <= pin_s;
         run       <= CW'(1);
         long_prev <= (run >= CW'(EDGE_HOLD));
      end else if (run != CW'(RUN_MAX)) begin
         run <= run + CW'(1);
      end
   end

   logic lvl_hit, edg_hit;
   assign lvl_hit = (run == CW'(LEVEL_HOLD));
   assign edg_hit = long_prev && (run == CW'(EDGE_HOLD));

   always_comb begin
      unique case (trig_cond_e'(cond))
         TRIG_LOW:  fire = !lvl_q && lvl_hit;
         TRIG_HIGH: fire =  lvl_q && lvl_hit;
         TRIG_FALL: fire = !lvl_q && edg_hit;
         TRIG_RISE: fire =  lvl_q && edg_hit;
         default:   fire = 1'b0;
      endcase
   end

   // R10: a qualified run yields one acceptance, not a stream.
   assert_fire_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (!fire || !$stable(cond)));

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NUM_CH = 12,
   parameter int IW     = 4,
   parameter int FW     = 5
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [FW-1:0]     from,
   output logic              found,
   output logic [IW-1:0]     idx
);

   generate
      if (NUM_CH > (1 << IW) || (1 << FW) <= NUM_CH) begin : g_bad_width
         $error("adc_chan_pick: index widths too narrow for NUM_CH");
      end
   endgenerate

   // Walk downward so the lowest qualifying channel is the one left standing.
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (mask[i] && (FW'(i) >= from)) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end

endmodule

// File: rtl/adc_eoc_flag.sv
module adc_eoc_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic irq_en,
   output logic flag,
   output logic irq
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag_q <= 1'b0;
      else if (set) flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;
   assign irq  = flag_q & irq_en;

   // R8: sticky until written clear; clear alone removes it.
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !clr) |=> flag_q);
   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag_q);

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH      = 12,
   parameter int CH_W        = 4,
   parameter int LEVEL_HOLD  = 8,
   parameter int EDGE_HOLD   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_mode,
   input  logic [NUM_CH-1:0] cfg_chan_mask,
   input  logic              cfg_irq_en,
   input  logic              cfg_hw_trig_en,
   input  logic [1:0]        cfg_trig_cond,
   input  logic              sw_start_set,
   input  logic              sw_start_clr,
   input  logic              eoc_clr,
   input  logic              trig_pin,
   input  logic              conv_done,
   output logic              conv_start,
   output logic [CH_W-1:0]   cur_chan,
   output logic              busy,
   output logic              eoc_flag,
   output logic              irq
);

   localparam int FW = CH_W + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > (1 << CH_W)) begin : g_bad_ch
         $error("adc_scan_seq: NUM_CH must fit in CH_W bits");
      end
   endgenerate

   seq_state_e       st;
   logic             run_bit;
   logic [CH_W-1:0]  cur;
   seq_mode_e        mode;
   logic             trig_fire;
   logic [FW-1:0]    pick_from;
   logic             pick_found;
   logic [CH_W-1:0]  pick_idx;

   assign mode = seq_mode_e'(cfg_mode);

   adc_trig_qual #(
      .LEVEL_HOLD (LEVEL_HOLD),
      .EDGE_HOLD  (EDGE_HOLD),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_trig (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (trig_pin),
      .cond (cfg_trig_cond),
      .fire (trig_fire)
   );

   // A pass begins at channel 0; later picks resume just above the current one.
   assign pick_from = (st == ST_IDLE) ? '0 : ({1'b0, cur} + FW'(1));

   adc_chan_pick #(
      .NUM_CH(NUM_CH),
      .IW    (CH_W),
      .FW    (FW)
   ) u_pick (
      .mask (cfg_chan_mask),
      .from (pick_from),
      .found(pick_found),
      .idx  (pick_idx)
   );

   logic hw_go, start_req, abort, idle_empty, wait_last, pass_end;

   assign hw_go      = trig_fire && cfg_hw_trig_en && (mode == MODE_SCAN);
   assign start_req  = (sw_start_set || hw_go) && (mode != MODE_RSV) && cfg_enable;
   assign abort      = sw_start_clr || !cfg_enable;
   assign idle_empty = (st == ST_IDLE) && run_bit && !pick_found;
   assign wait_last  = (st == ST_WAIT) && conv_done &&
                       ((mode == MODE_ONE) || !pick_found);
   assign pass_end   = !abort && (idle_empty || wait_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         run_bit <= 1'b0;
         cur     <= '0;
      end else if (abort) begin
         st      <= ST_IDLE;
         run_bit <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (run_bit) begin
                  if (pick_found) begin
                     cur <= pick_idx;
                     st  <= ST_ISSUE;
                  end else if (mode != MODE_LOOP) begin
                     run_bit <= 1'b0;
                  end
               end else if (start_req) begin
                  run_bit <= 1'b1;
               end
            end
            ST_ISSUE: st <= ST_WAIT;
            ST_WAIT: begin
               if (conv_done) begin
                  if (mode == MODE_ONE || !pick_found) begin
                     st <= ST_IDLE;
                     if (mode != MODE_LOOP) run_bit <= 1'b0;
                  end else begin
                     cur <= pick_idx;
                     st  <= ST_ISSUE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   adc_eoc_flag u_eoc (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (pass_end),
      .clr   (eoc_clr),
      .irq_en(cfg_irq_en),
      .flag  (eoc_flag),
      .irq   (irq)
   );

   assign conv_start = (st == ST_ISSUE);
   assign cur_chan   = cur;
   assign busy       = run_bit;

   assert_busy_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cfg_enable));
   assert_start_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   assert_start_in_run_R12: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);
   assert_loop_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_mode == 2'b11 && cfg_enable && !sw_start_clr) |=> busy);
   assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sw_start_clr |=> (!busy && !conv_start));
   assert_pick_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pick_found |-> (|(cfg_chan_mask & (NUM_CH'(1) << pick_idx)) &&
                      ({1'b0, pick_idx} >= pick_from)));

endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

   localparam int NUM_CH   = 12;
   localparam int CH_W     = 4;
   localparam int CONV_LAT = 3;

   typedef struct packed {
      logic [1:0]  mode;
      logic [11:0] mask;
      logic        int_en;
      logic [11:0] exp_visit;
      logic [4:0]  exp_n;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'b00, 12'h0A4, 1'b1, 12'h004, 5'd1},
      '{2'b10, 12'h0A4, 1'b0, 12'h0A4, 5'd3},
      '{2'b10, 12'hFFF, 1'b1, 12'hFFF, 5'd12},
      '{2'b10, 12'h801, 1'b1, 12'h801, 5'd2},
      '{2'b00, 12'h800, 1'b0, 12'h800, 5'd1},
      '{2'b10, 12'h000, 1'b1, 12'h000, 5'd0},
      '{2'b00, 12'h000, 1'b0, 12'h000, 5'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_enable = 1'b1;
   logic [1:0]        cfg_mode = 2'b00;
   logic [NUM_CH-1:0] cfg_chan_mask = '0;
   logic              cfg_irq_en = 1'b0;
   logic              cfg_hw_trig_en = 1'b0;
   logic [1:0]        cfg_trig_cond = 2'b11;
   logic              sw_start_set = 1'b0;
   logic              sw_start_clr = 1'b0;
   logic              eoc_clr = 1'b0;
   logic              trig_pin = 1'b0;
   logic              conv_done = 1'b0;
   logic              conv_start;
   logic [CH_W-1:0]   cur_chan;
   logic              busy;
   logic              eoc_flag;
   logic              irq;

   always #4 clk = ~clk;

   adc_scan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_adc_scan_seq (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
      .cfg_chan_mask(cfg_chan_mask), .cfg_irq_en(cfg_irq_en),
      .cfg_hw_trig_en(cfg_hw_trig_en), .cfg_trig_cond(cfg_trig_cond),
      .sw_start_set(sw_start_set), .sw_start_clr(sw_start_clr), .eoc_clr(eoc_clr),
      .trig_pin(trig_pin), .conv_done(conv_done), .conv_start(conv_start),
      .cur_chan(cur_chan), .busy(busy), .eoc_flag(eoc_flag), .irq(irq)
   );

   // Converter model: logs each started channel, answers after CONV_LAT cycles.
   int         conv_cnt = 0;
   int         lat_ctr = 0;
   logic [3:0] log_ch [256];

   always @(negedge clk) begin
      if (!rst_n) begin
         conv_done = 1'b0;
         lat_ctr   = 0;
      end else begin
         conv_done = 1'b0;
         if (lat_ctr > 0) begin
            lat_ctr--;
            if (lat_ctr == 0) conv_done = 1'b1;
         end
         if (conv_start) begin
            if (conv_cnt < 256) log_ch[conv_cnt] = cur_chan;
            conv_cnt++;
            lat_ctr = CONV_LAT;
         end
      end
   end

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_start();
      sw_start_set = 1'b1; tick(1); sw_start_set = 1'b0;
   endtask

   task automatic pulse_stop();
      sw_start_clr = 1'b1; tick(1); sw_start_clr = 1'b0;
   endtask

   task automatic pulse_eoc_clr();
      eoc_clr = 1'b1; tick(1); eoc_clr = 1'b0;
   endtask

   task automatic wait_idle();
      int t = 0;
      while (busy && t < 400) begin tick(1); t++; end
   endtask

   task automatic hold(input logic v, input int n);
      trig_pin = v; tick(n);
   endtask

   function automatic string vec_tag(input vec_t e);
      if (e.mask == 12'h000) return "R7";
      else if (e.mode == 2'b00) return "R2";
      else return "R3";
   endfunction

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL R12 watchdog: got %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int base;
      int c0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R13 reset state
      chk(busy == 1'b0 && conv_start == 1'b0, "R13", "busy/start after reset", busy, 0);
      chk(eoc_flag == 1'b0 && irq == 1'b0, "R13", "flag/irq after reset", eoc_flag, 0);
      chk(cur_chan == 4'd0, "R13", "cur_chan after reset", cur_chan, 0);

      // Vector table: mode, mask, interrupt enable -> channels visited
      for (int v = 0; v < NV; v++) begin
         logic [11:0] vis;
         bit          asc;
         int          n;
         cfg_mode      = VECS[v].mode;
         cfg_chan_mask = VECS[v].mask;
         cfg_irq_en    = VECS[v].int_en;
         pulse_eoc_clr();
         base = conv_cnt;
         pulse_start();
         chk(busy == 1'b1, "R12", "busy after start", busy, 1);
         wait_idle();
         tick(2);
         n   = conv_cnt - base;
         vis = '0;
         asc = 1'b1;
         for (int k = 0; k < n; k++) begin
            vis[log_ch[base+k]] = 1'b1;
            if (k > 0 && log_ch[base+k] <= log_ch[base+k-1]) asc = 1'b0;
         end
         chk(vis == VECS[v].exp_visit, vec_tag(VECS[v]), "channels visited",
             int'(vis), int'(VECS[v].exp_visit));
         chk(n == int'(VECS[v].exp_n) && asc, vec_tag(VECS[v]), "count/order",
             n, int'(VECS[v].exp_n));
         chk(eoc_flag == 1'b1 && busy == 1'b0, vec_tag(VECS[v]), "end flag set, idle",
             eoc_flag, 1);
         chk(irq == VECS[v].int_en, "R8", "irq follows enable", irq, int'(VECS[v].int_en));
      end

      // R4 continuous scan over channels 1 and 2
      cfg_mode = 2'b11; cfg_chan_mask = 12'h006;
      pulse_eoc_clr();
      base = conv_cnt;
      pulse_start();
      begin
         int t = 0;
         while (conv_cnt - base < 6 && t < 400) begin tick(1); t++; end
      end
      chk(busy == 1'b1, "R4", "still busy in continuous", busy, 1);
      for (int k = 0; k < 6; k++)
         chk(log_ch[base+k] == ((k % 2 == 1) ? 4'd2 : 4'd1), "R4", "repeat order",
             log_ch[base+k], (k % 2 == 1) ? 2 : 1);
      chk(eoc_flag == 1'b1, "R4", "flag per pass", eoc_flag, 1);

      // R5 stop request
      pulse_stop();
      chk(busy == 1'b0, "R5", "busy after stop", busy, 0);
      c0 = conv_cnt;
      tick(20);
      chk(conv_cnt == c0, "R5", "no start after stop", conv_cnt - c0, 0);

      // R6 enable drop aborts, and blocks start
      cfg_chan_mask = 12'h001;
      pulse_start();
      tick(10);
      cfg_enable = 1'b0;
      tick(1);
      chk(busy == 1'b0, "R6", "abort on disable", busy, 0);
      c0 = conv_cnt;
      tick(20);
      pulse_start();
      chk(busy == 1'b0, "R6", "start while disabled", busy, 0);
      tick(20);
      chk(conv_cnt == c0, "R6", "no conversion while disabled", conv_cnt - c0, 0);
      cfg_enable = 1'b1;

      // R1 reserved mode ignores start
      cfg_mode = 2'b01;
      c0 = conv_cnt;
      pulse_start();
      chk(busy == 1'b0, "R1", "reserved mode busy", busy, 0);
      tick(20);
      chk(conv_cnt == c0, "R1", "reserved mode conversions", conv_cnt - c0, 0);

      // R8 write-one-to-clear
      cfg_irq_en = 1'b1;
      tick(1);
      chk(eoc_flag == 1'b1 && irq == 1'b1, "R8", "flag held before clear", eoc_flag, 1);
      pulse_eoc_clr();
      chk(eoc_flag == 1'b0 && irq == 1'b0, "R8", "flag after clear", eoc_flag, 0);

      // Hardware trigger, scan-once on channel 0
      cfg_mode = 2'b10; cfg_chan_mask = 12'h001; cfg_hw_trig_en = 1'b1;
      cfg_trig_cond = 2'b11;
      hold(1'b0, 12);
      base = conv_cnt;
      hold(1'b1, 3); hold(1'b0, 20);
      chk(conv_cnt == base, "R11", "3-cycle rising pulse rejected", conv_cnt - base, 0);
      base = conv_cnt;
      hold(1'b1, 4); hold(1'b0, 20);
      chk(conv_cnt - base == 1, "R11", "4-cycle rising edge accepted", conv_cnt - base, 1);
      chk(busy == 1'b0 && eoc_flag == 1'b1, "R9", "trigger run ended", busy, 0);

      cfg_trig_cond = 2'b10;
      base = conv_cnt;
      hold(1'b1, 10); hold(1'b0, 20);
      chk(conv_cnt - base == 1, "R10", "falling edge accepted", conv_cnt - base, 1);

      cfg_trig_cond = 2'b01;
      base = conv_cnt;
      hold(1'b1, 7); hold(1'b0, 20);
      chk(conv_cnt == base, "R10", "high level 7 cycles rejected", conv_cnt - base, 0);
      base = conv_cnt;
      hold(1'b1, 8); hold(1'b0, 20);
      chk(conv_cnt - base == 1, "R10", "high level 8 cycles accepted", conv_cnt - base, 1);

      cfg_trig_cond = 2'b00;
      base = conv_cnt;
      hold(1'b1, 10); hold(1'b0, 7); hold(1'b1, 5);
      chk(conv_cnt == base, "R10", "low level 7 cycles rejected", conv_cnt - base, 0);
      base = conv_cnt;
      hold(1'b0, 20);
      chk(conv_cnt - base == 1, "R10", "low level held accepted", conv_cnt - base, 1);

      cfg_trig_cond = 2'b11;
      cfg_mode = 2'b00;
      base = conv_cnt;
      hold(1'b1, 6); hold(1'b0, 20);
      chk(conv_cnt == base && busy == 1'b0, "R9", "trigger ignored in single mode",
          conv_cnt - base, 0);

      cfg_mode = 2'b10; cfg_hw_trig_en = 1'b0;
      base = conv_cnt;
      hold(1'b1, 6); hold(1'b0, 20);
      chk(conv_cnt == base, "R9", "trigger ignored when disabled", conv_cnt - base, 0);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule